// File: doc/BRIEF.md
# Dual-Line Secondary Interrupt Stage

This block collects up to `NSRC` interrupt sources (24 by default) for one peripheral module and reports them to two independent host interrupt lines. Every source passes through a two-flop synchroniser and an edge detector. A single edge-select table decides for each source whether a rising edge, a falling edge, either edge, or no edge counts as an event. The edge-select table is shared by both lines. Each line has its own status and mask registers, so two hosts can each handle their own subset of the sources.

Software uses a byte-wide register port with a one-cycle read latency. Through this port it reads status, programs masks and edge selection, and sets a control byte. The control byte selects how status is acknowledged: clear-on-read, or write-one-to-clear. It also turns off the single-deep pending buffer, which keeps a second event that arrives while a status bit is still set. Each line drives an active-low interrupt output. The output is low while any unmasked status bit of that line is set.

Top module: `dual_irq_stage`

## Requirements
- R1: After synchronous reset, all mask bits of both lines are 1, all status, pending and edge-select bits are 0, the control byte is 0 and both `irq_n` bits are 1.
- R2: The edge-select bytes start at address 0x10. Source i uses byte 0x10 + i/4. Bit 2*(i%4)+1 of that byte enables rising-edge events and bit 2*(i%4) enables falling-edge events. With both bits set, either edge is an event.
- R3: A source whose two edge-select bits are both 0 never sets status on either line, whatever its input does.
- R4: Line 0 has status bytes at 0x00–0x02 and mask bytes at 0x04–0x06. Line 1 has status bytes at 0x08–0x0A and mask bytes at 0x0C–0x0E. Byte k holds sources 8k..8k+7, with source 8k in bit 0. A mask bit of 1 stops that source from setting status on that line.
- R5: One event on a source sets status on every line where that source is unmasked.
- R6: `irq_n[L]` goes low one cycle after line L has a set, unmasked status bit. It returns high one cycle after that condition ends, whether the status bit was cleared or masked.
- R7: Control bit 0 at address 0x18 set to 1 selects clear-on-read. A status read returns the bits as they were and then clears them. Writes to status bytes are ignored in this mode.
- R8: Control bit 0 set to 0 selects write-one-to-clear. Writing 1 to a status bit clears it, writing 0 leaves it as it is, and reads do not clear.
- R9: An event on a source whose status bit is already set is held as pending. When the bit is cleared, it reads 0 for one cycle and is then set again. Setting control bit 1 to 1 turns off this pending buffer.
- R10: If an event and a clear reach the same status bit in the same cycle, the bit stays set.
- R11: `reg_rdata` shows the addressed byte in the cycle after `reg_rd` is asserted. Addresses that map to no register read as 0.
- R12: A change on `src_in` before clock edge k sets status at edge k+2. A read captured at edge k+2 still returns 0, and a read captured at edge k+3 returns the new bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_in | input | NSRC | Asynchronous interrupt source levels |
| reg_addr | input | 6 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe; in clear-on-read mode it also acknowledges |
| reg_rdata | output | 8 | Read data, registered |
| irq_n | output | 2 | Active-low interrupt per host line |

## Verification
A source change becomes status three register stages later. Two stages are synchroniser flops and the third is the status flop. The interrupt output follows one stage after status. A register read shows the value from just before its own capture edge.

The bench always drives and samples on the falling clock edge and counts rising edges explicitly. It samples one edge early to confirm that a result is not yet visible, then samples at the edge where the result is due. This covers the output latency, the one-cycle gap in the pending reassertion, and the interrupt release after a mask write. To test the collision case, a clear write is placed on the exact edge where a new event lands.

// File: rtl/dis_pkg.sv
package dis_pkg;

    localparam int ADDR_W = 6;

    // control byte address and edge bank base
    localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_EDGE = 6'h10;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_STA,
        RG_MSK,
        RG_EDGE,
        RG_CTRL
    } region_e;

    typedef struct packed {
        region_e    region;
        logic       line;
        logic [2:0] idx;
    } decode_t;

    // bit0: clear-on-read, bit1: pending buffer disabled
    typedef struct packed {
        logic pend_off;
        logic cor;
    } ctrl_t;

    function automatic decode_t decode_addr(input logic [ADDR_W-1:0] a,
                                            input int nbytes,
                                            input int ebytes);
        decode_t d;
        d.region = RG_NONE;
        d.line   = a[3];
        d.idx    = a[2:0];
        if (a[5:4] == 2'b00) begin
            d.idx = {1'b0, a[1:0]};
            if (int'(a[1:0]) < nbytes)
                d.region = a[2] ? RG_MSK : RG_STA;
        end else if (a[5:3] == OFS_EDGE[5:3]) begin
            if (int'(a[2:0]) < ebytes)
                d.region = RG_EDGE;
        end else if (a == OFS_CTRL) begin
            d.region = RG_CTRL;
        end
        return d;
    endfunction

endpackage

// File: rtl/dis_edge_detect.sv
module dis_edge_detect #(
    parameter int NSRC = 24
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_in,
    input  logic [NSRC-1:0] rise_en,
    input  logic [NSRC-1:0] fall_en,
    output logic [NSRC-1:0] ev
);

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            logic s1_q, s2_q, prev_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    s1_q   <= 1'b0;
                    s2_q   <= 1'b0;
                    prev_q <= 1'b0;
                end else begin
                    s1_q   <= src_in[i];
                    s2_q   <= s1_q;
                    prev_q <= s2_q;
                end
            end

            assign ev[i] = (rise_en[i] &  s2_q & ~prev_q)
                         | (fall_en[i] & ~s2_q &  prev_q);
        end
    endgenerate

endmodule

// File: rtl/dis_line.sv
module dis_line #(
    parameter int NSRC   = 24,
    parameter int NBYTES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   ev,
    input  logic              pend_off,
    input  logic [NSRC-1:0]   clr,
    input  logic [NBYTES-1:0] mask_we,
    input  logic [7:0]        wdata,
    output logic [NSRC-1:0]   sta,
    output logic [NSRC-1:0]   mask,
    output logic [NSRC-1:0]   pend,
    output logic              irq_n
);

    localparam int PADW = NBYTES * 8;

    logic [NSRC-1:0] live, sta_d, pend_d, mask_d;
    logic [PADW-1:0] mask_pad;

    always_comb begin
        live   = ev & ~mask;
        // a new event beats a clear; a buffered event reloads an empty bit
        sta_d  = live | (sta & ~clr) | (~sta & pend);
        pend_d = (pend & sta) | ({NSRC{~pend_off}} & live & sta & ~clr);

        mask_pad             = '0;
        mask_pad[NSRC-1:0]   = mask;
        for (int b = 0; b < NBYTES; b++) begin
            if (mask_we[b])
                mask_pad[b*8 +: 8] = wdata;
        end
        mask_d = mask_pad[NSRC-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sta   <= '0;
            pend  <= '0;
            mask  <= '1;
            irq_n <= 1'b1;
        end else begin
            sta   <= sta_d;
            pend  <= pend_d;
            mask  <= mask_d;
            irq_n <= ~|(sta & ~mask);
        end
    end

endmodule

// File: rtl/dis_regfile.sv
module dis_regfile
    import dis_pkg::*;
#(
    parameter int NSRC   = 24,
    parameter int NBYTES = 3,
    parameter int EBYTES = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   wr,
    input  logic [7:0]             wdata,
    input  logic                   rd,
    input  logic [1:0][NSRC-1:0]   sta,
    input  logic [1:0][NSRC-1:0]   msk,
    output logic [7:0]             rdata,
    output ctrl_t                  ctrl,
    output logic [NSRC-1:0]        rise_en,
    output logic [NSRC-1:0]        fall_en,
    output logic [1:0][NSRC-1:0]   clr,
    output logic [1:0][NBYTES-1:0] mask_we
);

    localparam int PADW = NBYTES * 8;
    localparam int EW   = EBYTES * 8;

    decode_t               dec;
    logic [EW-1:0]         edge_q;
    logic [1:0][PADW-1:0]  sta_pad, msk_pad, clr_pad;
    logic [7:0]            rd_val;

    assign dec = decode_addr(addr, NBYTES, EBYTES);

    // per-line acknowledge and mask-write strobes
    always_comb begin
        for (int l = 0; l < 2; l++) begin
            sta_pad[l]            = '0;
            msk_pad[l]            = '0;
            sta_pad[l][NSRC-1:0]  = sta[l];
            msk_pad[l][NSRC-1:0]  = msk[l];
            clr_pad[l]            = '0;
            mask_we[l]            = '0;
            for (int b = 0; b < NBYTES; b++) begin
                if (int'(dec.idx) == b && dec.line == l[0]) begin
                    if (dec.region == RG_STA) begin
                        if (rd && ctrl.cor)
                            clr_pad[l][b*8 +: 8] = 8'hFF;
                        if (wr && !ctrl.cor)
                            clr_pad[l][b*8 +: 8] = clr_pad[l][b*8 +: 8] | wdata;
                    end
                    if (dec.region == RG_MSK && wr)
                        mask_we[l][b] = 1'b1;
                end
            end
            clr[l] = clr_pad[l][NSRC-1:0];
        end
    end

    // read multiplexer
    always_comb begin
        rd_val = '0;
        case (dec.region)
            RG_STA: begin
                for (int b = 0; b < NBYTES; b++)
                    if (int'(dec.idx) == b) rd_val = sta_pad[dec.line][b*8 +: 8];
            end
            RG_MSK: begin
                for (int b = 0; b < NBYTES; b++)
                    if (int'(dec.idx) == b) rd_val = msk_pad[dec.line][b*8 +: 8];
            end
            RG_EDGE: begin
                for (int b = 0; b < EBYTES; b++)
                    if (int'(dec.idx) == b) rd_val = edge_q[b*8 +: 8];
            end
            RG_CTRL: rd_val = {6'b0, ctrl};
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_q <= '0;
            ctrl   <= '0;
            rdata  <= '0;
        end else begin
            if (rd)
                rdata <= rd_val;
            if (wr && dec.region == RG_CTRL)
                ctrl <= ctrl_t'(wdata[1:0]);
            for (int b = 0; b < EBYTES; b++) begin
                if (wr && dec.region == RG_EDGE && int'(dec.idx) == b)
                    edge_q[b*8 +: 8] <= wdata;
            end
        end
    end

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_edge_map
            assign rise_en[i] = edge_q[2*i + 1];
            assign fall_en[i] = edge_q[2*i];
        end
    endgenerate

endmodule

// File: rtl/dual_irq_stage.sv
module dual_irq_stage
    import dis_pkg::*;
#(
    parameter int NSRC = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_rd,
    output logic [7:0]        reg_rdata,
    output logic [1:0]        irq_n
);

    localparam int NBYTES = (NSRC + 7) / 8;
    localparam int EBYTES = (2 * NSRC + 7) / 8;

    ctrl_t                  ctrl_w;
    logic [NSRC-1:0]        rise_w, fall_w, ev_w;
    logic [1:0][NSRC-1:0]   sta_w, msk_w, clr_w, pend_w;
    logic [1:0][NBYTES-1:0] mwe_w;

    dis_edge_detect #(.NSRC(NSRC)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .src_in  (src_in),
        .rise_en (rise_w),
        .fall_en (fall_w),
        .ev      (ev_w)
    );

    dis_regfile #(.NSRC(NSRC), .NBYTES(NBYTES), .EBYTES(EBYTES)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (reg_addr),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .rd      (reg_rd),
        .sta     (sta_w),
        .msk     (msk_w),
        .rdata   (reg_rdata),
        .ctrl    (ctrl_w),
        .rise_en (rise_w),
        .fall_en (fall_w),
        .clr     (clr_w),
        .mask_we (mwe_w)
    );

    generate
        for (genvar l = 0; l < 2; l++) begin : g_line
            dis_line #(.NSRC(NSRC), .NBYTES(NBYTES)) u_line (
                .clk      (clk),
                .rst      (rst),
                .ev       (ev_w),
                .pend_off (ctrl_w.pend_off),
                .clr      (clr_w[l]),
                .mask_we  (mwe_w[l]),
                .wdata    (reg_wdata),
                .sta      (sta_w[l]),
                .mask     (msk_w[l]),
                .pend     (pend_w[l]),
                .irq_n    (irq_n[l])
            );
        end
    endgenerate

endmodule

// File: rtl/dis_checker.sv
module dis_checker #(
    parameter int NSRC = 24
) (
    input logic                 clk,
    input logic                 rst,
    input logic [1:0]           irq_n,
    input logic [1:0][NSRC-1:0] sta,
    input logic [1:0][NSRC-1:0] msk,
    input logic [1:0][NSRC-1:0] clr,
    input logic [1:0][NSRC-1:0] pend,
    input logic [NSRC-1:0]      ev,
    input logic [NSRC-1:0]      rise_en,
    input logic [NSRC-1:0]      fall_en
);

    // R3: no event from a source with no edge selected
    assert_edge_none_R3: assert property (@(posedge clk) disable iff (rst)
        (ev & ~(rise_en | fall_en)) == '0);

    generate
        for (genvar l = 0; l < 2; l++) begin : g_chk
            assert_mask_reset_R1: assert property (@(posedge clk) disable iff (rst)
                $fell(rst) |-> (msk[l] == {NSRC{1'b1}} && sta[l] == '0 && irq_n[l]));

            assert_irq_low_R6: assert property (@(posedge clk) disable iff (rst)
                !irq_n[l] |-> $past(|(sta[l] & ~msk[l])));

            assert_irq_set_R6: assert property (@(posedge clk) disable iff (rst)
                $past(|(sta[l] & ~msk[l])) |-> !irq_n[l]);

            assert_fall_needs_clear_R8: assert property (@(posedge clk) disable iff (rst)
                ($past(sta[l]) & ~sta[l] & ~$past(clr[l])) == '0);

            assert_rise_needs_cause_R9: assert property (@(posedge clk) disable iff (rst)
                (~$past(sta[l]) & sta[l] & ~$past((ev & ~msk[l]) | pend[l])) == '0);

            assert_event_wins_R10: assert property (@(posedge clk) disable iff (rst)
                ($past(ev & ~msk[l]) & ~sta[l]) == '0);
        end
    endgenerate

endmodule

bind dual_irq_stage dis_checker #(.NSRC(NSRC)) u_dis_checker (
    .clk     (clk),
    .rst     (rst),
    .irq_n   (irq_n),
    .sta     (sta_w),
    .msk     (msk_w),
    .clr     (clr_w),
    .pend    (pend_w),
    .ev      (ev_w),
    .rise_en (rise_w),
    .fall_en (fall_w)
);

// File: tb/dual_irq_stage_bench.sv
module dual_irq_stage_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC       = 24;

    logic            clk = 1'b0;
    logic            rst;
    logic [NSRC-1:0] src_in;
    logic [5:0]      reg_addr;
    logic            reg_wr;
    logic [7:0]      reg_wdata;
    logic            reg_rd;
    logic [7:0]      reg_rdata;
    logic [1:0]      irq_n;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_irq_stage #(.NSRC(NSRC)) u_dual_irq_stage (
        .clk       (clk),
        .rst       (rst),
        .src_in    (src_in),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata),
        .irq_n     (irq_n)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic t_reset;
        chk("R1 irq_n", {6'b0, irq_n}, 8'h03);
        for (int b = 0; b < 3; b++) begin
            rd_chk("R1 mask0", 6'h04 + 6'(b), 8'hFF);
            rd_chk("R1 mask1", 6'h0C + 6'(b), 8'hFF);
            rd_chk("R1 sta0", 6'h00 + 6'(b), 8'h00);
            rd_chk("R1 sta1", 6'h08 + 6'(b), 8'h00);
        end
        for (int b = 0; b < 6; b++) rd_chk("R1 edge", 6'h10 + 6'(b), 8'h00);
        rd_chk("R1 ctrl", 6'h18, 8'h00);
    endtask

    // source 5: edge byte 0x11 bits 3/2, status byte 0 bit 5
    task automatic t_edges;
        wr(6'h11, 8'h08);
        wr(6'h04, 8'hDF);
        src_in[5] = 1'b1; step(3);
        rd_chk("R2 rise sets", 6'h00, 8'h20);
        rd_chk("R8 read keeps", 6'h00, 8'h20);
        wr(6'h00, 8'h00);
        rd_chk("R8 zero write keeps", 6'h00, 8'h20);
        wr(6'h00, 8'h20);
        rd_chk("R8 one write clears", 6'h00, 8'h00);
        src_in[5] = 1'b0; step(3);
        rd_chk("R2 fall ignored in rise mode", 6'h00, 8'h00);
        wr(6'h11, 8'h04);
        src_in[5] = 1'b1; step(3);
        rd_chk("R2 rise ignored in fall mode", 6'h00, 8'h00);
        src_in[5] = 1'b0; step(3);
        rd_chk("R2 fall sets", 6'h00, 8'h20);
        wr(6'h00, 8'h20);
        wr(6'h11, 8'h00);
        src_in[5] = 1'b1; step(3);
        rd_chk("R3 no edge no status", 6'h00, 8'h00);
        chk("R3 irq stays high", {7'b0, irq_n[0]}, 8'h01);
        src_in[5] = 1'b0; step(3);
        rd_chk("R3 no edge fall", 6'h00, 8'h00);
        wr(6'h11, 8'h0C);
        src_in[5] = 1'b1; step(3);
        rd_chk("R2 both edges rise", 6'h00, 8'h20);
        wr(6'h00, 8'h20);
        src_in[5] = 1'b0; step(3);
        rd_chk("R2 both edges fall", 6'h00, 8'h20);
        wr(6'h00, 8'h20);
        wr(6'h11, 8'h00);
        wr(6'h04, 8'hFF);
    endtask

    // source 17: edge byte 0x14 bit 3, status byte 2 bit 1
    task automatic t_lines;
        wr(6'h14, 8'h08);
        wr(6'h0E, 8'hFD);
        src_in[17] = 1'b1;
        step(2);
        rd_chk("R12 not yet at k+2", 6'h0A, 8'h00);
        chk("R6 irq not yet", {6'b0, irq_n}, 8'h03);
        rd_chk("R12 set at k+3", 6'h0A, 8'h02);
        chk("R6 irq line1 low", {6'b0, irq_n}, 8'h01);
        rd_chk("R4 masked line0 unset", 6'h02, 8'h00);
        wr(6'h0E, 8'hFF);
        chk("R6 irq still low after mask edge", {6'b0, irq_n}, 8'h01);
        step(1);
        chk("R6 irq released by mask", {6'b0, irq_n}, 8'h03);
        rd_chk("R4 mask keeps status", 6'h0A, 8'h02);
        wr(6'h0A, 8'h02);
        rd_chk("R4 line1 cleared", 6'h0A, 8'h00);
        wr(6'h06, 8'hFD);
        wr(6'h0E, 8'hFD);
        src_in[17] = 1'b0; step(3);
        src_in[17] = 1'b1; step(3);
        rd_chk("R5 line0 shared", 6'h02, 8'h02);
        rd_chk("R5 line1 shared", 6'h0A, 8'h02);
        chk("R5 both irq low", {6'b0, irq_n}, 8'h00);
        wr(6'h02, 8'h02);
        wr(6'h0A, 8'h02);
        step(1);
        chk("R6 both released", {6'b0, irq_n}, 8'h03);
        src_in[17] = 1'b0;
        wr(6'h06, 8'hFF);
        wr(6'h0E, 8'hFF);
        wr(6'h14, 8'h00);
        step(3);
    endtask

    // source 2: edge byte 0x10 bits 5/4, status byte 0 bit 2
    task automatic t_cor;
        wr(6'h18, 8'h01);
        wr(6'h10, 8'h20);
        wr(6'h04, 8'hFB);
        src_in[2] = 1'b1; step(3);
        wr(6'h00, 8'h04);
        rd_chk("R7 write ignored, read returns bits", 6'h00, 8'h04);
        rd_chk("R7 read cleared", 6'h00, 8'h00);
        chk("R7 irq released", {7'b0, irq_n[0]}, 8'h01);
        src_in[2] = 1'b0;
        wr(6'h18, 8'h00);
        step(3);
    endtask

    task automatic t_pend;
        src_in[2] = 1'b1; step(3);
        src_in[2] = 1'b0; step(2);
        src_in[2] = 1'b1; step(3);
        wr(6'h00, 8'h04);
        rd_chk("R9 gap after clear", 6'h00, 8'h00);
        rd_chk("R9 pending reasserts", 6'h00, 8'h04);
        wr(6'h00, 8'h04);
        rd_chk("R9 pending consumed", 6'h00, 8'h00);
        rd_chk("R9 stays clear", 6'h00, 8'h00);
        wr(6'h18, 8'h02);
        src_in[2] = 1'b0; step(2);
        src_in[2] = 1'b1; step(3);
        src_in[2] = 1'b0; step(2);
        src_in[2] = 1'b1; step(3);
        wr(6'h00, 8'h04);
        rd_chk("R9 no buffer gap", 6'h00, 8'h00);
        rd_chk("R9 no buffer reload", 6'h00, 8'h00);
        src_in[2] = 1'b0; step(3);
    endtask

    task automatic t_collide;
        wr(6'h10, 8'h30);
        src_in[2] = 1'b1; step(3);
        rd_chk("R10 setup", 6'h00, 8'h04);
        src_in[2] = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        wr(6'h00, 8'h04);
        rd_chk("R10 event beats clear", 6'h00, 8'h04);
        wr(6'h00, 8'h04);
        rd_chk("R10 later clear works", 6'h00, 8'h00);
        wr(6'h10, 8'h00);
        wr(6'h04, 8'hFF);
        wr(6'h18, 8'h00);
    endtask

    task automatic t_unmapped;
        rd_chk("R11 status hole", 6'h03, 8'h00);
        rd_chk("R11 mask hole", 6'h0F, 8'h00);
        rd_chk("R11 edge hole", 6'h16, 8'h00);
        rd_chk("R11 high hole", 6'h3F, 8'h00);
        rd_chk("R11 ctrl readback", 6'h18, 8'h00);
    endtask

    initial begin
        rst = 1'b1; src_in = '0; reg_addr = '0; reg_wr = 1'b0;
        reg_wdata = '0; reg_rd = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step(1);
        t_reset();
        t_edges();
        t_lines();
        t_cor();
        t_pend();
        t_collide();
        t_unmapped();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule